// File: doc/BRIEF.md
# LPC Firmware Memory Read Target

This block is the target side of a Low Pin Count bus for firmware-memory reads. It watches the 4-bit multiplexed LAD bus and the active-low frame strobe. When a firmware-read cycle addressed to its strap ID arrives, it captures a 28-bit byte address and a burst size. It then takes the bus, signals ready, and streams the requested bytes back one nibble per clock.

Bytes come from an attached byte-wide memory through a simple synchronous read port. The port has a one-clock latency and receives one request per byte. Requests are issued far enough ahead that every byte is on hand before its first nibble goes out. Cycles that are not for this target, or that carry an unsupported size, leave LAD undriven.

Top module: `lpc_fw_read_target`

## Requirements
- R1: A cycle starts only from a START nibble sampled while `frame_ni` is low. If `frame_ni` stays low for several clocks, only the nibble on the last low clock counts. Only 1101b starts a firmware read; any other value gets no response.
- R2: The nibble after START must equal `id_i`; on a mismatch `lad_oe_o` stays low for the whole cycle.
- R3: The next seven nibbles form the 28-bit start address, most significant nibble first.
- R4: The size nibble must be one of the codes 0, 1, 2, 4 or 7, which select 2^code bytes. Any other code gets no response.
- R5: After the host's first turnaround clock (1111b), the target drives LAD with 1111b in the next clock, which is clock 12 of the cycle.
- R6: One clock of ready sync (0000b) follows, and the first data nibble comes in the clock after it.
- R7: Bytes leave in ascending address order from the start address, wrapping modulo 2^28. Each byte is sent low nibble first, then high nibble.
- R8: After the last data nibble the target drives 1111b for one clock and then releases LAD. Data ends on clock 13 + 2^(code+1) of the cycle.
- R9: Each byte is fetched by exactly one single-clock `mem_rd_o` pulse carrying its address on `mem_addr_o`. `mem_data_i` is taken one clock after the pulse, and pulses occur only while the target drives LAD.
- R10: When `frame_ni` is sampled low, any response in progress stops and `lad_oe_o` is low in the following clock. After reset, `lad_oe_o` and `mem_rd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Frame strobe, active low |
| id_i | input | 4 | Strap ID matched against the ID nibble |
| lad_i | input | 4 | LAD value seen on the bus |
| lad_o | output | 4 | LAD value driven by the target |
| lad_oe_o | output | 1 | Output enable for `lad_o` |
| mem_rd_o | output | 1 | Memory read request, one pulse per byte |
| mem_addr_o | output | 28 | Byte address of the request |
| mem_data_i | input | 8 | Read data, valid the clock after the request |

## Verification
The assertions take for granted that the host keeps `frame_ni` high while the target owns LAD, except when it deliberately aborts. They also assume the memory answers each request exactly one clock later. The stimulus respects both assumptions. It begins each new cycle only after the closing turnaround, and models the memory as a register loaded on every request pulse. The one deliberate abort pulls `frame_ni` low in the middle of a burst, so the bench can confirm that the release is immediate.

// File: rtl/lpc_fw_pkg.sv
package lpc_fw_pkg;
  localparam logic [3:0] START_FW_READ = 4'b1101;
  localparam logic [3:0] NIB_ONES      = 4'hF;
  localparam logic [3:0] NIB_READY     = 4'h0;
  localparam int         MAX_MSIZE     = 7;

  typedef enum logic [1:0] {RX_IDLE, RX_ID, RX_ADDR, RX_SIZE} rx_state_e;
  typedef enum logic [2:0] {TX_IDLE, TX_TAR, TX_SYNC, TX_DATA, TX_END} tx_state_e;

  function automatic logic size_legal(input logic [3:0] code);
    return (code == 4'd0) || (code == 4'd1) || (code == 4'd2) ||
           (code == 4'd4) || (code == 4'd7);
  endfunction
endpackage

// File: rtl/lpc_fw_hdr_rx.sv
module lpc_fw_hdr_rx
  import lpc_fw_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int MS_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [3:0]        lad_i,
  input  logic [3:0]        id_i,
  output logic              go_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [MS_W-1:0]   msize_o
);
  localparam int ADDR_NIB = ADDR_W / 4;
  localparam int ACNT_W   = $clog2(ADDR_NIB);

  rx_state_e         state_q;
  logic [ACNT_W-1:0] acnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [MS_W-1:0]   msize_q;
  logic              go_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      acnt_q  <= '0;
      addr_q  <= '0;
      msize_q <= '0;
      go_q    <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (!frame_ni) begin
        // the last START nibble before frame rises wins
        state_q <= (lad_i == START_FW_READ) ? RX_ID : RX_IDLE;
      end else begin
        unique case (state_q)
          RX_ID: begin
            acnt_q  <= '0;
            state_q <= (lad_i == id_i) ? RX_ADDR : RX_IDLE;
          end
          RX_ADDR: begin
            addr_q <= {addr_q[ADDR_W-5:0], lad_i};
            acnt_q <= acnt_q + 1'b1;
            if (acnt_q == ACNT_W'(ADDR_NIB - 1)) state_q <= RX_SIZE;
          end
          RX_SIZE: begin
            if (size_legal(lad_i)) begin
              go_q    <= 1'b1;
              msize_q <= lad_i[MS_W-1:0];
            end
            state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign go_o    = go_q;
  assign addr_o  = addr_q;
  assign msize_o = msize_q;
endmodule

// File: rtl/lpc_fw_data_tx.sv
module lpc_fw_data_tx
  import lpc_fw_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int MS_W   = 3,
  parameter int NCNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MS_W-1:0]   msize_i,
  input  logic [7:0]        mem_data_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o
);
  tx_state_e         state_q;
  logic [NCNT_W-1:0] nib_q, last_q;
  logic [ADDR_W-1:0] next_q, maddr_q;
  logic [3:0]        lad_q, hi_q;
  logic              oe_q, rd_q;
  logic              more_bytes;

  // another byte remains beyond the one being loaded now
  assign more_bytes = ({1'b0, nib_q} + (NCNT_W+1)'(3)) <= {1'b0, last_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      nib_q   <= '0;
      last_q  <= '0;
      next_q  <= '0;
      maddr_q <= '0;
      lad_q   <= NIB_ONES;
      hi_q    <= '0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else if (!frame_ni) begin
      state_q <= TX_IDLE;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
      lad_q   <= NIB_ONES;
    end else begin
      rd_q <= 1'b0;
      unique case (state_q)
        TX_IDLE: begin
          if (go_i) begin
            state_q <= TX_TAR;
            oe_q    <= 1'b1;
            lad_q   <= NIB_ONES;
            rd_q    <= 1'b1;
            maddr_q <= addr_i;
            next_q  <= addr_i + 1'b1;
            nib_q   <= '0;
            last_q  <= NCNT_W'((32'd2 << msize_i) - 32'd1);
          end
        end
        TX_TAR: begin
          lad_q   <= NIB_READY;
          state_q <= TX_SYNC;
        end
        TX_SYNC: begin
          lad_q   <= mem_data_i[3:0];
          hi_q    <= mem_data_i[7:4];
          state_q <= TX_DATA;
          if (last_q > NCNT_W'(1)) begin
            rd_q    <= 1'b1;
            maddr_q <= next_q;
            next_q  <= next_q + 1'b1;
          end
        end
        TX_DATA: begin
          if (nib_q == last_q) begin
            lad_q   <= NIB_ONES;
            state_q <= TX_END;
          end else begin
            nib_q <= nib_q + 1'b1;
            if (!nib_q[0]) begin
              lad_q <= hi_q;
            end else begin
              lad_q <= mem_data_i[3:0];
              hi_q  <= mem_data_i[7:4];
              if (more_bytes) begin
                rd_q    <= 1'b1;
                maddr_q <= next_q;
                next_q  <= next_q + 1'b1;
              end
            end
          end
        end
        TX_END: begin
          oe_q    <= 1'b0;
          state_q <= TX_IDLE;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign lad_o      = lad_q;
  assign lad_oe_o   = oe_q;
  assign mem_rd_o   = rd_q;
  assign mem_addr_o = maddr_q;
endmodule

// File: rtl/lpc_fw_read_target.sv
module lpc_fw_read_target
  import lpc_fw_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [3:0]        id_i,
  input  logic [3:0]        lad_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i
);
  localparam int MS_W   = $clog2(MAX_MSIZE + 1);
  localparam int NCNT_W = MAX_MSIZE + 1;

  logic              go;
  logic [ADDR_W-1:0] hdr_addr;
  logic [MS_W-1:0]   hdr_msize;

  lpc_fw_hdr_rx #(.ADDR_W(ADDR_W), .MS_W(MS_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_ni (frame_ni),
    .lad_i    (lad_i),
    .id_i     (id_i),
    .go_o     (go),
    .addr_o   (hdr_addr),
    .msize_o  (hdr_msize)
  );

  lpc_fw_data_tx #(.ADDR_W(ADDR_W), .MS_W(MS_W), .NCNT_W(NCNT_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_ni   (frame_ni),
    .go_i       (go),
    .addr_i     (hdr_addr),
    .msize_i    (hdr_msize),
    .mem_data_i (mem_data_i),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .lad_o      (lad_o),
    .lad_oe_o   (lad_oe_o)
  );
endmodule

// File: rtl/lpc_fw_read_target_chk.sv
module lpc_fw_read_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_ni,
  input logic [3:0] lad_o,
  input logic       lad_oe_o,
  input logic       mem_rd_o
);
  p_take_bus_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lad_oe_o) |-> lad_o == 4'hF);

  p_sync_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lad_oe_o) && frame_ni) |=> (lad_oe_o && lad_o == 4'h0));

  p_abort_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ni |=> !lad_oe_o);

  p_rd_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  p_rd_in_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> lad_oe_o);

  p_release_after_ones_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lad_oe_o) && $past(frame_ni)) |-> $past(lad_o) == 4'hF);
endmodule

bind lpc_fw_read_target lpc_fw_read_target_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .frame_ni (frame_ni),
  .lad_o    (lad_o),
  .lad_oe_o (lad_oe_o),
  .mem_rd_o (mem_rd_o)
);

// File: tb/lpc_fw_read_target_tb.sv
module lpc_fw_read_target_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  strap_id = 4'hA;
  logic [3:0]  lad_in = 4'h0;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        mem_rd;
  logic [27:0] mem_addr;
  logic [7:0]  mem_q = 8'h00;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  int rd_cnt = 0;
  bit run = 1'b0;
  string idle_tag = "R10";

  logic [3:0] exp_lad[int];
  string      exp_req[int];

  lpc_fw_read_target u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .frame_ni   (frame_n),
    .id_i       (strap_id),
    .lad_i      (lad_in),
    .lad_o      (lad_out),
    .lad_oe_o   (lad_oe),
    .mem_rd_o   (mem_rd),
    .mem_addr_o (mem_addr),
    .mem_data_i (mem_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [27:0] a);
    return a[7:0] ^ {a[11:8], a[27:24]} ^ a[19:12] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) begin
      mem_q  <= mem_fn(mem_addr);
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (run) begin
      if (exp_lad.exists(cyc))
        check(lad_oe === 1'b1 && lad_out === exp_lad[cyc], exp_req[cyc], "oe/lad",
              {3'b0, lad_oe, lad_out}, {4'h1, exp_lad[cyc]});
      else
        check(lad_oe === 1'b0, idle_tag, "oe idle", {7'b0, lad_oe}, 8'h00);
    end
  end

  task automatic drive(input logic f, input logic [3:0] l);
    @(negedge clk);
    frame_n = f;
    lad_in  = l;
    if (!f)
      for (int k = cyc + 1; k < cyc + 400; k++)
        if (exp_lad.exists(k)) begin
          exp_lad.delete(k);
          exp_req.delete(k);
        end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 4'hA);
  endtask

  // returns rd count snapshot taken at the ID nibble
  task automatic send_cycle(input logic [3:0] first_st, input int extra_low,
                            input logic [3:0] last_st, input logic [3:0] idsel,
                            input logic [27:0] addr, input logic [3:0] msz,
                            input bit accept, output int rd_base);
    int t0;
    int nb;
    for (int i = 0; i < extra_low; i++) drive(1'b0, first_st);
    drive(1'b0, last_st);
    t0 = cyc;
    drive(1'b1, idsel);
    rd_base = rd_cnt;
    for (int i = 6; i >= 0; i--) drive(1'b1, addr[i*4 +: 4]);
    drive(1'b1, msz);
    drive(1'b1, 4'hF);
    if (accept) begin
      nb = 1 << msz;
      exp_lad[t0+11] = 4'hF; exp_req[t0+11] = "R5";
      exp_lad[t0+12] = 4'h0; exp_req[t0+12] = "R6";
      for (int b = 0; b < nb; b++) begin
        logic [7:0] d;
        d = mem_fn(addr + 28'(b));
        exp_lad[t0+13+2*b] = d[3:0]; exp_req[t0+13+2*b] = "R3/R7";
        exp_lad[t0+14+2*b] = d[7:4]; exp_req[t0+14+2*b] = "R3/R7";
      end
      exp_lad[t0+13+2*nb] = 4'hF; exp_req[t0+13+2*nb] = "R8";
    end
  endtask

  task automatic read_ok(input logic [27:0] addr, input logic [3:0] msz);
    int base;
    int nb;
    nb = 1 << msz;
    idle_tag = "R8";
    send_cycle(4'h0, 0, 4'hD, strap_id, addr, msz, 1'b1, base);
    idle(2*nb + 3);
    check(rd_cnt - base == nb, "R9", "read pulses", 8'(rd_cnt - base), 8'(nb));
  endtask

  task automatic read_none(input string tag, input logic [3:0] first_st, input int extra,
                           input logic [3:0] st, input logic [3:0] idsel,
                           input logic [3:0] msz);
    int base;
    idle_tag = tag;
    send_cycle(first_st, extra, st, idsel, 28'h0123456, msz, 1'b0, base);
    idle(6);
    check(rd_cnt == base, tag, "no read pulses", 8'(rd_cnt - base), 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check(lad_oe === 1'b0, "R10", "reset oe", {7'b0, lad_oe}, 8'h00);
    check(mem_rd === 1'b0, "R10", "reset rd", {7'b0, mem_rd}, 8'h00);
    run = 1'b1;
    idle(3);

    read_ok(28'h1234567, 4'd0);
    read_ok(28'hABCDEF0, 4'd1);
    read_ok(28'h00000FE, 4'd2);
    read_ok(28'hFFFFFF8, 4'd4);   // R7 address wrap
    read_ok(28'h3000080, 4'd7);

    read_none("R2", 4'h0, 0, 4'hD, 4'h5, 4'd0);
    read_none("R4", 4'h0, 0, 4'hD, strap_id, 4'd3);
    read_none("R4", 4'h0, 0, 4'hD, strap_id, 4'd8);
    read_none("R4", 4'h0, 0, 4'hD, strap_id, 4'hF);
    read_none("R1", 4'h0, 0, 4'h0, strap_id, 4'd0);
    read_none("R1", 4'hD, 2, 4'h2, strap_id, 4'd0);

    // R1 last START wins after frame held low
    idle_tag = "R1";
    send_cycle(4'h0, 2, 4'hD, strap_id, 28'h0C0FFEE, 4'd1, 1'b1, base);
    idle(7);

    // R2 new strap value
    strap_id = 4'h3;
    read_ok(28'h7654321, 4'd2);
    read_none("R2", 4'h0, 0, 4'hD, 4'hA, 4'd0);

    // back-to-back reads
    read_ok(28'h0000010, 4'd1);
    read_ok(28'h0000020, 4'd0);

    // R10 abort mid-burst then a fresh read
    idle_tag = "R10";
    send_cycle(4'h0, 0, 4'hD, strap_id, 28'h4444440, 4'd4, 1'b1, base);
    idle(8);
    read_ok(28'h5555550, 4'd0);
    idle(4);

    run = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule